// File: doc/BRIEF.md
# Sticky Tag-Fault Status Register

This block records tag-check faults that are reported after the fact, for one privilege level. A tag-check unit raises a one-cycle `fault_valid` strobe and presents the faulting virtual address at the same time. Address bit 55 picks which of two sticky flags the fault sets. Bit 0 marks faults in the lower address half and bit 1 marks faults in the upper half. A flag stays set until software overwrites it.

Software reads the register through `rd_data` and replaces its flags through a write port. Writing a zero is how a flag is cleared. The `host_mode` input gates the upper-half flag. While `host_mode` is low, that flag reads as zero, cannot be set by a fault and ignores software writes. Every bit above bit 1 is reserved: it always reads as zero and writes do not affect it.

Top module: `tag_fault_status`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, both flags are cleared and `rd_data` reads 0 after that edge.
- R2: A `fault_valid` pulse with `fault_addr[55]`=0 sets `rd_data[0]` to 1 from the next rising edge onward.
- R3: A `fault_valid` pulse with `fault_addr[55]`=1 while `host_mode`=1 sets `rd_data[1]` to 1 from the next rising edge onward.
- R4: While `host_mode`=0:
  - `rd_data[1]` reads 0.
  - A fault with `fault_addr[55]`=1 sets no flag.
  - A software write leaves the stored upper flag unchanged.
  - The stored upper flag becomes visible again once `host_mode` returns to 1.
- R5: Once set, a flag stays set across idle cycles and further faults, until a software write changes it.
- R6: A cycle with `sw_wr_en`=1 replaces the flags with `sw_wr_data[1:0]` at the next rising edge. Bit 1 is replaced only if `host_mode`=1.
- R7: When a write and a fault that sets the same flag occur in the same cycle, the flag ends up 1.
- R8: `rd_data[63:2]` is always 0, including after a write of all ones.
- R9: Only `fault_addr[55]` selects the flag. The other address bits have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fault_valid | input | 1 | One-cycle tag-check fault strobe |
| fault_addr | input | 64 | Virtual address of the fault |
| host_mode | input | 1 | Host-mode control; enables the upper-half flag |
| sw_wr_en | input | 1 | Software write strobe |
| sw_wr_data | input | 64 | Software write data |
| rd_data | output | 64 | Register read value |

## Verification
The bench targets four corner cases.
- A write that clears a flag in the same cycle as a fault that sets it. A design that gave the write priority would lose the fault, and bit 0 would read 0.
- A fault or write aimed at bit 1 while host mode is off. A design that gated only the read path would show a stale 1 once host mode returns.
- Fault addresses that have many other upper bits set. This exposes a design that decodes the wrong address bit.
- A write of all ones. A design that stored or passed the reserved bits would show nonzero upper bits.

// File: rtl/tag_fault_status.sv
module tag_fault_status #(
  parameter int DATA_W  = 64,
  parameter int ADDR_W  = 64,
  parameter int SEL_BIT = 55
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fault_valid,
  input  logic [ADDR_W-1:0] fault_addr,
  input  logic              host_mode,
  input  logic              sw_wr_en,
  input  logic [DATA_W-1:0] sw_wr_data,
  output logic [DATA_W-1:0] rd_data
);
  localparam int RSVD_W = DATA_W - 2;

  logic lo_q, hi_q;
  logic lo_hit, hi_hit, lo_base, hi_base;

  assign lo_hit  = fault_valid & ~fault_addr[SEL_BIT];
  assign hi_hit  = fault_valid &  fault_addr[SEL_BIT] & host_mode;
  assign lo_base = sw_wr_en ? sw_wr_data[0] : lo_q;
  assign hi_base = (sw_wr_en && host_mode) ? sw_wr_data[1] : hi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= 1'b0;
      hi_q <= 1'b0;
    end else begin
      lo_q <= lo_base | lo_hit;
      hi_q <= hi_base | hi_hit;
    end
  end

  assign rd_data = {{RSVD_W{1'b0}}, hi_q & host_mode, lo_q};

  a_r2_low_fault_sets: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid && !fault_addr[SEL_BIT] |=> rd_data[0]);
  a_r3_high_fault_sets: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid && fault_addr[SEL_BIT] && host_mode |=> hi_q);
  a_r4_high_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !host_mode |=> $stable(hi_q));
  a_r5_low_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    lo_q && !sw_wr_en |=> lo_q);
  a_r7_fault_beats_write: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr_en && !sw_wr_data[0] && fault_valid && !fault_addr[SEL_BIT] |=> lo_q);
endmodule

// File: tb/tb_tag_fault_status.sv
module tb_tag_fault_status;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        fault_valid = 0;
  logic [63:0] fault_addr = '0;
  logic        host_mode = 1;
  logic        sw_wr_en = 0;
  logic [63:0] sw_wr_data = '0;
  logic [63:0] rd_data;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  localparam logic [63:0] LO_ADDR = 64'h007F_FFFF_FFFF_FFFF;
  localparam logic [63:0] HI_ADDR = 64'h0080_0000_0000_0000;

  always #5 clk = ~clk;

  tag_fault_status dut (.*);

  task automatic check(string req, logic [63:0] exp);
    n_chk++;
    if (rd_data !== exp) begin
      n_bad++;
      $display("FAIL %s: rd_data=%h expected=%h", req, rd_data, exp);
    end
  endtask

  task automatic step(logic fv, logic [63:0] fa, logic we, logic [63:0] wd);
    fault_valid = fv; fault_addr = fa; sw_wr_en = we; sw_wr_data = wd;
    @(negedge clk);
    fault_valid = 0; sw_wr_en = 0; fault_addr = '0; sw_wr_data = '0;
  endtask

  task automatic t_reset();
    rst_n = 0;
    @(negedge clk); @(negedge clk);
    check("R1 reset", 64'd0);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic t_low_fault();
    step(1, LO_ADDR, 0, '0);
    check("R2 R9 low fault", 64'd1);
  endtask

  task automatic t_sticky();
    repeat (3) @(negedge clk);
    check("R5 idle", 64'd1);
    step(1, LO_ADDR, 0, '0);
    check("R5 repeat fault", 64'd1);
  endtask

  task automatic t_write();
    step(0, '0, 1, 64'd0);
    check("R6 clear", 64'd0);
    step(0, '0, 1, '1);
    check("R6 R8 write ones", 64'd3);
    step(0, '0, 1, 64'd0);
    check("R6 clear both", 64'd0);
  endtask

  task automatic t_high_fault();
    step(1, HI_ADDR, 0, '0);
    check("R3 R9 high fault", 64'd2);
    step(0, '0, 1, 64'd0);
    check("R6 clear high", 64'd0);
  endtask

  task automatic t_host_off();
    step(1, HI_ADDR, 0, '0);
    host_mode = 0;
    @(negedge clk);
    check("R4 read masked", 64'd0);
    step(0, '0, 1, 64'd0);
    check("R4 write ignored off", 64'd0);
    host_mode = 1;
    @(negedge clk);
    check("R4 stored flag kept", 64'd2);
    step(0, '0, 1, 64'd0);
    host_mode = 0;
    step(1, HI_ADDR, 0, '0);
    step(0, '0, 1, 64'd3);
    check("R6 low written host off", 64'd1);
    host_mode = 1;
    @(negedge clk);
    check("R4 no high set when off", 64'd1);
    step(0, '0, 1, 64'd0);
  endtask

  task automatic t_race();
    step(1, LO_ADDR, 0, '0);
    step(1, LO_ADDR, 1, 64'd0);
    check("R7 low race", 64'd1);
    step(1, HI_ADDR, 1, 64'd0);
    check("R7 high race", 64'd2);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_low_fault();
    t_sticky();
    t_write();
    t_high_fault();
    t_host_off();
    t_race();
    t_reset();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100us;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: rd_data=%h expected=completion", rd_data);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule